// File: doc/BRIEF.md
# Byte-Command I2C Bus Master

This block is a single-master I2C controller that software steers one byte at a time through a small 8-bit register window. Software sets a 16-bit bus-clock divider and turns the core on. It then writes a data byte and a command that asks for any mix of these steps, always in the same order: a START, one byte written or read, and a STOP. The controller runs the requested steps on the two bus lines. When it finishes, it sets a completion flag and can raise an interrupt.

Both bus lines are open-drain. The block only reports when it wants a line pulled low, and a pull-up outside the block supplies the high level. Every bit period has four equal phases, and each phase lasts `divider + 1` system clocks. Each phase boundary moves at most one of the two lines, so SDA and SCL never change in the same clock. A START, including a repeated START, always drops SDA while SCL is high and drops SCL one phase later.

Top module: `i2c_byte_master`

## Requirements
- R1: Register window, one byte per access. Address 0 holds the divider low byte and address 1 the divider high byte; both are write-only and read as 0x00. Address 2 is control, read back with bits 5..0 as zero. Address 4 writes the transmit byte and reads the receive byte. Address 5 writes a command and reads status.
- R2: Each bit period is four phases of `divider + 1` clocks. Successive SCL rising edges inside one byte are therefore `4*(divider+1)` clocks apart.
- R3: Bus outputs are drive-low requests (1 = pull low, 0 = release), and both are 0 after reset. The SDA level is read back on `sda_in`.
- R4: `scl_drive_low` and `sda_drive_low` never change in the same clock cycle.
- R5: Command bit 7 requests a START. SDA falls while SCL is released, and SCL falls exactly `divider + 1` clocks later. A START issued after a finished byte (a repeated START) first releases SDA, then SCL, before doing the same.
- R6: Command bit 4 writes the transmit byte MSB first. The line level on the ninth SCL high is stored in status bit 7, where 1 means NACK.
- R7: Command bit 5 reads a byte MSB first into the receive register. On the ninth clock the master sends command bit 3: 0 pulls SDA low (ACK) and 1 releases it (NACK).
- R8: Command bit 6 requests a STOP. SDA rises while SCL is released. Status bit 6 (bus busy) is set by this master's START and cleared by its STOP.
- R9: Status bit 0 is set when a command sequence completes. Writing a command with bit 0 set clears it. `irq` is high exactly when this flag and control bit 6 are both 1.
- R10: Status bit 1 is high while a sequence runs. A command is taken only when control bit 7 is 1, no sequence is running, and at least one of command bits 7..4 is set; any other command write starts nothing.
- R11: Status bit 5 is set when SDA reads low during the SCL-high phase of a written data bit that the master left released. It is cleared when the next command is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
The bench puts a bus decoder and a simple slave on the wired lines. It targets the repeated START: a design that drops both lines together produces no START on the bus, so the scoreboard sees a missing event. It also watches the START-to-SCL-fall gap and the per-bit SCL period, which catch an off-by-one in the divider. Read bytes are checked with both ACK settings, and a NACK from the slave must appear in status. The bench issues commands while the core is disabled and while a sequence is running; a design that accepts them puts stray STARTs or STOPs on the bus. A slave that holds SDA low during a released bit must set the arbitration flag, and that flag must clear on the next command.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       scl_drive_low,
  output logic       sda_drive_low,
  input  logic       sda_in
);
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_BIT = 2'd2, S_STOP = 2'd3;

  logic [DIV_W-1:0] div, cnt;
  logic       en, ien;
  logic [7:0] txd, rxd, sh;
  logic       p_sto, p_rd, p_wr, p_ack;
  logic [1:0] st, ph;
  logic [3:0] bitn;
  logic       rxack, busy, al, tip, iflag;
  logic       scl_l, sda_l;

  wire cmd_wr = wr_en && addr == 3'd5;
  wire go     = cmd_wr && en && !tip && |wdata[7:4];
  wire tick   = tip && cnt == div;

  assign scl_drive_low = scl_l;
  assign sda_drive_low = sda_l;
  assign irq = iflag & ien;

  always_comb begin
    case (addr)
      3'd2:    rdata = {en, ien, 6'b0};
      3'd4:    rdata = rxd;
      3'd5:    rdata = {rxack, busy, al, 3'b0, tip, iflag};
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '1; en <= 1'b0; ien <= 1'b0; txd <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: div[7:0] <= wdata;
        3'd1: div[DIV_W-1:8] <= wdata[DIV_W-9:0];
        3'd2: {en, ien} <= wdata[7:6];
        3'd4: txd <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; cnt <= '0; sh <= '0; rxd <= '0;
      p_sto <= 1'b0; p_rd <= 1'b0; p_wr <= 1'b0; p_ack <= 1'b0;
      rxack <= 1'b0; busy <= 1'b0; al <= 1'b0; tip <= 1'b0; iflag <= 1'b0;
      scl_l <= 1'b0; sda_l <= 1'b0;
    end else begin
      if (cmd_wr && wdata[0]) iflag <= 1'b0;
      if (go) begin
        tip <= 1'b1; al <= 1'b0; ph <= '0; bitn <= '0; cnt <= '0; sh <= txd;
        {p_sto, p_rd, p_wr, p_ack} <= {wdata[6:4], wdata[3]};
        st <= wdata[7] ? S_START : (|wdata[5:4]) ? S_BIT : S_STOP;
      end else if (tip) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          ph <= ph + 1'b1;
          case (st)
            S_START: case (ph)
              2'd0: sda_l <= 1'b0;
              2'd1: scl_l <= 1'b0;
              2'd2: begin sda_l <= 1'b1; busy <= 1'b1; end
              default: begin
                scl_l <= 1'b1;
                if (p_rd || p_wr) st <= S_BIT;
                else if (p_sto) st <= S_STOP;
                else begin st <= S_IDLE; tip <= 1'b0; iflag <= 1'b1; end
              end
            endcase
            S_BIT: case (ph)
              2'd0: sda_l <= (bitn < 4'd8) ? (p_wr & ~sh[7]) : (p_rd & ~p_ack);
              2'd1: scl_l <= 1'b0;
              2'd2: begin
                if (bitn < 4'd8) begin
                  sh <= {sh[6:0], sda_in};
                  if (p_wr && !sda_l && !sda_in) al <= 1'b1;
                end else if (p_wr) rxack <= sda_in;
              end
              default: begin
                scl_l <= 1'b1;
                if (bitn == 4'd8) begin
                  if (p_rd) rxd <= sh;
                  if (p_sto) st <= S_STOP;
                  else begin st <= S_IDLE; tip <= 1'b0; iflag <= 1'b1; end
                end else bitn <= bitn + 1'b1;
              end
            endcase
            S_STOP: case (ph)
              2'd0: sda_l <= 1'b1;
              2'd1: scl_l <= 1'b0;
              2'd2: begin sda_l <= 1'b0; busy <= 1'b0; end
              default: begin st <= S_IDLE; tip <= 1'b0; iflag <= 1'b1; end
            endcase
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_l,
  input logic       sda_l,
  input logic       busy,
  input logic       tip,
  input logic       iflag,
  input logic       en,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [1:0] st
);
  a_r4_one_line_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_l) && !$stable(sda_l)));
  a_r5_sda_edge_in_high_only_framing: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_l) && !scl_l && !$past(scl_l)) |-> (st == 2'd1 || st == 2'd3));
  a_r8_busy_set_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sda_l && !scl_l));
  a_r8_busy_clear_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!sda_l && !scl_l));
  a_r9_flag_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iflag) |-> !tip);
  a_r10_disabled_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5 && !en && !tip) |=> !tip);
endmodule

bind i2c_byte_master i2c_byte_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_l(scl_l), .sda_l(sda_l), .busy(busy),
  .tip(tip), .iflag(iflag), .en(en), .wr_en(wr_en), .addr(addr), .st(st)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  localparam int DIVV = 1;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, sda_in;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq, scl_dl, sda_dl;
  int checks = 0, errors = 0, r4_bad = 0;

  always #2.5 clk = ~clk;

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .scl_drive_low(scl_dl), .sda_drive_low(sda_dl), .sda_in(sda_in)
  );

  // slave model: 1 = ack a write, 2 = send s_byte, 3 = hold bit 2 low and ack
  int smode = 0, arm_no = -1, byte_no = 0;
  logic [3:0] bcnt = '0;
  logic [7:0] s_byte = '0;
  logic s_nack = 1'b0, slave_low;
  assign slave_low = (arm_no == byte_no) &&
    ((smode == 1 && bcnt == 4'd8 && !s_nack) ||
     (smode == 2 && bcnt < 4'd8 && !s_byte[3'd7 - bcnt[2:0]]) ||
     (smode == 3 && (bcnt == 4'd2 || bcnt == 4'd8)));
  assign sda_in = ~(sda_dl | slave_low);

  // scoreboard items: [10:9] kind (0 START, 1 STOP, 2 byte), [8] ack level, [7:0] data
  logic [10:0] exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic emit(input logic [10:0] ev);
    logic [10:0] e;
    if (exp_q.size() == 0) check(0, "R5/R6/R7/R8 unexpected bus event", int'(ev), 0);
    else begin
      e = exp_q.pop_front();
      check(ev == e, "R5/R6/R7/R8 bus event", int'(ev), int'(e));
    end
  endtask

  int cyc = 0, t_start = 0, t_rise = 0, nb = 0;
  bit p_scl = 1, p_sda = 1, p_sdl = 0, p_dl = 0, skip = 0, chk_start = 0;
  logic [8:0] shv = '0;
  always @(negedge clk) begin
    bit scl_n, sda_n;
    cyc++;
    scl_n = ~scl_dl;
    sda_n = sda_in;
    if (rst_n) begin
      if (scl_dl != p_sdl && sda_dl != p_dl) r4_bad++;
      if (p_scl && scl_n && p_sda && !sda_n) begin
        emit(11'h000); nb = 0; skip = 1; bcnt = 0; t_start = cyc; chk_start = 1;
      end else if (p_scl && scl_n && !p_sda && sda_n) begin
        emit(11'h200); nb = 0;
      end
      if (!p_scl && scl_n) begin
        if (nb >= 1 && nb <= 8) check(cyc - t_rise == 4*(DIVV+1), "R2 SCL period", cyc - t_rise, 4*(DIVV+1));
        t_rise = cyc;
        shv = {shv[7:0], sda_n};
        nb++;
        if (nb == 9) begin emit({2'd2, shv[0], shv[8:1]}); nb = 0; end
      end
      if (p_scl && !scl_n) begin
        if (chk_start) check(cyc - t_start == DIVV+1, "R5 SDA-to-SCL fall gap", cyc - t_start, DIVV+1);
        chk_start = 0;
        if (skip) skip = 0;
        else if (bcnt == 4'd8) begin bcnt = 0; byte_no++; end
        else bcnt++;
      end
    end
    p_scl = scl_n; p_sda = sda_n; p_sdl = scl_dl; p_dl = sda_dl;
  end

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); wr_en = 1'b0; addr = a; #0.5; d = rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    for (int i = 0; i < 4000; i++) begin
      rreg(3'd5, s);
      if (!s[1]) return;
    end
    check(0, "R10 sequence never finished", 1, 0);
  endtask

  task automatic arm(input int mode, input logic [7:0] b, input bit nack);
    smode = mode; s_byte = b; s_nack = nack; arm_no = byte_no;
  endtask

  task automatic push_s(); exp_q.push_back(11'h000); endtask
  task automatic push_p(); exp_q.push_back(11'h200); endtask
  task automatic push_b(input logic [7:0] d, input bit a); exp_q.push_back({2'd2, a, d}); endtask

  initial begin
    logic [7:0] v;
    #1000000;
    check(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rreg(3'd5, v); check(v == 8'h00, "R9/R10 status after reset", v, 0);
    rreg(3'd2, v); check(v == 8'h00, "R1 control after reset", v, 0);
    check(irq == 0, "R9 irq after reset", irq, 0);
    check(scl_dl == 0 && sda_dl == 0, "R3 lines released after reset", {scl_dl, sda_dl}, 0);

    wreg(3'd0, DIVV[7:0]); wreg(3'd1, 8'h00); wreg(3'd2, 8'h40);
    wreg(3'd5, 8'h91);
    repeat (20) @(negedge clk);
    rreg(3'd5, v); check(v[1] == 0, "R10 command ignored while disabled", v, 0);
    check(scl_dl == 0 && sda_dl == 0, "R10 bus untouched while disabled", {scl_dl, sda_dl}, 0);

    wreg(3'd2, 8'hC0);
    rreg(3'd2, v); check(v == 8'hC0, "R1 control readback", v, 8'hC0);
    rreg(3'd0, v); check(v == 8'h00, "R1 divider low write-only", v, 0);
    rreg(3'd1, v); check(v == 8'h00, "R1 divider high write-only", v, 0);

    wreg(3'd4, 8'h3A); arm(1, 8'h00, 0);
    push_s(); push_b(8'h3A, 0);
    wreg(3'd5, 8'h91);
    wreg(3'd5, 8'h40);
    wait_done();
    rreg(3'd5, v); check(v == 8'h41, "R6/R8/R9/R10 status after START+write with ACK", v, 8'h41);
    check(irq == 1, "R9 irq raised", irq, 1);
    wreg(3'd5, 8'h01);
    check(irq == 0, "R9 IACK clears irq", irq, 0);

    wreg(3'd4, 8'hC5); arm(1, 8'h00, 1);
    push_b(8'hC5, 1);
    wreg(3'd5, 8'h11); wait_done();
    rreg(3'd5, v); check(v[7] == 1, "R6 NACK from slave in status bit 7", v[7], 1);

    wreg(3'd4, 8'h3B); arm(1, 8'h00, 0);
    push_s(); push_b(8'h3B, 0);
    wreg(3'd5, 8'h91); wait_done();
    rreg(3'd5, v); check(v[7] == 0 && v[6] == 1, "R5/R6 repeated START then ACK", v, 8'h41);

    arm(2, 8'hA6, 0);
    push_b(8'hA6, 1); push_p();
    wreg(3'd5, 8'h69); wait_done();
    rreg(3'd4, v); check(v == 8'hA6, "R7 read data with NACK", v, 8'hA6);
    rreg(3'd5, v); check(v[6] == 0, "R8 busy cleared by STOP", v[6], 0);

    wreg(3'd4, 8'h3B); arm(1, 8'h00, 0);
    push_s(); push_b(8'h3B, 0);
    wreg(3'd5, 8'h91); wait_done();
    arm(2, 8'h5C, 0);
    push_b(8'h5C, 0);
    wreg(3'd5, 8'h21); wait_done();
    rreg(3'd4, v); check(v == 8'h5C, "R7 read data with ACK", v, 8'h5C);
    push_p();
    wreg(3'd5, 8'h41); wait_done();

    wreg(3'd4, 8'hFF); arm(3, 8'h00, 0);
    push_s(); push_b(8'hDF, 0);
    wreg(3'd5, 8'h91); wait_done();
    rreg(3'd5, v); check(v[5] == 1, "R11 arbitration lost flagged", v[5], 1);
    push_p();
    wreg(3'd5, 8'h41); wait_done();
    rreg(3'd5, v); check(v[5] == 0 && v[6] == 0, "R11 flag cleared by next command", v, 1);

    wreg(3'd2, 8'h80); wreg(3'd5, 8'h01);
    wreg(3'd4, 8'h3A); arm(1, 8'h00, 0);
    push_s(); push_b(8'h3A, 0);
    wreg(3'd5, 8'h90); wait_done();
    rreg(3'd5, v); check(v[0] == 1 && irq == 0, "R9 flag set but irq masked", {v[0], irq}, 2);
    push_p();
    wreg(3'd5, 8'h41); wait_done();

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5/R6/R7/R8 all expected bus events seen", exp_q.size(), 0);
    check(r4_bad == 0, "R4 no simultaneous line changes", r4_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule